// File: doc/BRIEF.md
# Pipelined Min-Heap Replacement Queue

This block keeps a binary min-heap of K entries. Each entry pairs a miss-frequency priority with the index of the victim-storage slot that holds the block. The root always carries the lowest priority, so a caller can compare an evicted block's frequency against it at once. It admits the block only when that frequency is at least the root value. The heap offers a single operation, replace. A replace aimed at the root writes the new (priority, slot) pair there and lets it sink toward the leaves. A replace aimed at any other node removes that entry by giving it priority zero, which then rises to the root.

Sinking runs one tree level per pipeline stage, so a second root replace may begin while an earlier one is still moving down the lower levels. A slot-to-node map is kept beside the heap. With it the victim storage can find the node that holds a given slot when that slot is freed, and can issue the zero-priority replace against it. Nodes are numbered from 1 at the root. Node i has children 2i and 2i+1.

Top module: `mhq_heap`

## Requirements
- R1: After a synchronous active-low reset, node n holds priority 0 and slot n-1. The map returns node p+1 for slot p. The minimum outputs show priority 0 and slot 0, and ready is high.
- R2: Whenever no root replace is waiting in the first stage, min_prio equals the smallest priority held in the heap, and min_ptr names a slot whose priority equals it.
- R3: cmp_ge is high exactly when cmp_freq, compared as unsigned, is greater than or equal to min_prio.
- R4: A replace accepted with req_node = 1 stores (req_prio, req_ptr) and restores heap order by sinking the entry. The root shows the new minimum on the second rising edge after acceptance, and that minimum is at most req_prio.
- R5: A replace accepted with req_node other than 1 forces priority zero and ignores req_prio. On the first edge after acceptance, the root holds priority 0 with slot req_ptr.
- R6: After a root replace is accepted, req_ready is low for the next cycle, so root replaces start at most every second cycle. A replace aimed at a node other than 1 is accepted only when no sink operation is in flight at any level.
- R7: Once all operations have finished, map_node(p) gives the node that holds slot p. The map over all slots is a permutation of 1..K, and the root slot maps to node 1.
- R8: Root replaces that start while earlier ones are still sinking give the same minimum sequence as if they had run one at a time.
- R9: Removal at node i shifts each entry on the path from the root to i down by one level, parent into child. For example, removal at node 5 after reset moves slot 0 to node 2, slot 1 to node 5 and the removed slot to node 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Replace request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_node | input | NW | Target node, 1 = root (sink), other = removal |
| req_prio | input | PW | Priority for a root replace |
| req_ptr | input | SW | Slot index carried by the new entry |
| min_prio | output | PW | Priority at the root |
| min_ptr | output | SW | Slot at the root |
| cmp_freq | input | PW | Frequency to compare against the root |
| cmp_ge | output | 1 | cmp_freq >= min_prio |
| map_ptr | input | SW | Slot to look up |
| map_node | output | NW | Node currently holding map_ptr |

## Verification
The overlap that matters is a fresh root replace reading level one while an older replace is still writing two or more levels down. The bench provokes it by issuing a new root replace as soon as ready returns. It then judges each resulting minimum against a priority model kept per slot. Long bursts of computed priorities, including ties, are followed by map-permutation checks. A removal presented while a sink is still in flight is also tried. The bench expects ready to stay low for that removal while a root request in the same cycle is accepted.

// File: rtl/mhq_pkg.sv
// Package for the min-heap replacement queue.
// Holds the operation kind and a helper that gives the tree level of a node index.
package mhq_pkg;

    // Kind of replace, decided by the target node.
    typedef enum logic {
        OP_SINK = 1'b0,
        OP_RISE = 1'b1
    } mhq_op_e;

    // Tree level of node n (root = level 0); n must be >= 1.
    function automatic int level_of(input int n);
        int lv;
        lv = 0;
        for (int b = 1; b < 32; b++) begin
            if ((n >> b) != 0) lv = b;
        end
        return lv;
    endfunction

endpackage

// File: rtl/mhq_sift_unit.sv
// One sink step: the carried entry meets the two children of its node.
// The smaller child is chosen, left on a tie. A swap happens only when that child is strictly smaller.
// Assumes both children exist, so the caller places it only on levels above the leaves.
module mhq_sift_unit #(
    parameter int PW = 8,
    parameter int SW = 4,
    parameter int NW = 4
) (
    input  logic [NW-1:0] node,
    input  logic [PW-1:0] carry_prio,
    input  logic [SW-1:0] carry_ptr,
    input  logic [PW-1:0] left_prio,
    input  logic [SW-1:0] left_ptr,
    input  logic [PW-1:0] right_prio,
    input  logic [SW-1:0] right_ptr,
    output logic          go_down,
    output logic [NW-1:0] next_node,
    output logic [PW-1:0] wr_prio,
    output logic [SW-1:0] wr_ptr
);
    logic          pick_right;
    logic [PW-1:0] kid_prio;
    logic [SW-1:0] kid_ptr;

    // Choose the smaller child and decide whether the carried entry moves down.
    always_comb begin
        pick_right = right_prio < left_prio;
        kid_prio   = pick_right ? right_prio : left_prio;
        kid_ptr    = pick_right ? right_ptr  : left_ptr;
        go_down    = kid_prio < carry_prio;
        wr_prio    = go_down ? kid_prio : carry_prio;
        wr_ptr     = go_down ? kid_ptr  : carry_ptr;
        next_node  = {node[NW-2:0], pick_right};
    end
endmodule

// File: rtl/mhq_path_mask.sv
// Marks every node on the path from the root down to a target node, the target included.
// Assumes 1 <= target <= K.
module mhq_path_mask #(
    parameter int K  = 15,
    parameter int NW = 4
) (
    input  logic [NW-1:0] target,
    output logic [K:1]    on_path
);
    int tgt_lv;

    // Level of the target from its highest set bit.
    always_comb begin
        tgt_lv = 0;
        for (int b = 0; b < NW; b++) begin
            if (target[b]) tgt_lv = b;
        end
    end

    for (genvar n = 1; n <= K; n++) begin : g_node
        localparam int NLV = mhq_pkg::level_of(n);
        // A node lies on the path if the target shifted up to the node's level equals it.
        always_comb begin
            on_path[n] = (tgt_lv >= NLV) && ((target >> (tgt_lv - NLV)) == NW'(n));
        end
    end
endmodule

// File: rtl/mhq_heap.sv
// Pipelined min-heap of (priority, slot) pairs with a slot-to-node map.
// A root replace sinks one level per stage, and root replaces may start every second cycle.
// A removal (any other node) writes priority zero and lifts the root-to-node path in one cycle.
// It is accepted only when no sink is in flight.
// Assumes K = 2^D - 1 with D >= 2, and slot indices in the heap kept distinct by the caller.
module mhq_heap #(
    parameter int K  = 15,
    parameter int PW = 8,
    localparam int D  = $clog2(K + 1),
    localparam int NW = D,
    localparam int SW = (K > 1) ? $clog2(K) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [NW-1:0] req_node,
    input  logic [PW-1:0] req_prio,
    input  logic [SW-1:0] req_ptr,
    output logic [PW-1:0] min_prio,
    output logic [SW-1:0] min_ptr,
    input  logic [PW-1:0] cmp_freq,
    output logic          cmp_ge,
    input  logic [SW-1:0] map_ptr,
    output logic [NW-1:0] map_node
);
    import mhq_pkg::*;

    logic [PW-1:0] hp_prio [1:K];
    logic [SW-1:0] hp_ptr  [1:K];
    logic [NW-1:0] loc     [0:K-1];

    logic [D-1:0]  st_vld;
    logic [NW-1:0] st_node [D];
    logic [PW-1:0] st_prio [D];
    logic [SW-1:0] st_ptr  [D];

    logic          st_go    [D];
    logic [NW-1:0] st_next  [D];
    logic [PW-1:0] st_wprio [D];
    logic [SW-1:0] st_wptr  [D];

    logic [K:1]    up_mask;
    mhq_op_e       req_op;
    logic          acc_sink;
    logic          acc_rise;

    // Decode the request kind and the handshake.
    always_comb begin
        req_op    = (req_node == NW'(1)) ? OP_SINK : OP_RISE;
        req_ready = !st_vld[0] && ((req_op == OP_SINK) || (st_vld == '0));
        acc_sink  = req_valid && req_ready && (req_op == OP_SINK);
        acc_rise  = req_valid && req_ready && (req_op == OP_RISE);
    end

    // Root view, comparison and slot lookup.
    always_comb begin
        min_prio = hp_prio[1];
        min_ptr  = hp_ptr[1];
        cmp_ge   = cmp_freq >= hp_prio[1];
        map_node = loc[map_ptr];
    end

    mhq_path_mask #(.K(K), .NW(NW)) u_path (
        .target  (req_node),
        .on_path (up_mask)
    );

    for (genvar L = 0; L < D; L++) begin : g_lvl
        if (L < D - 1) begin : g_inner
            logic [NW-1:0] cl;
            logic [NW-1:0] cr;
            // Child indices of the node this stage holds.
            always_comb begin
                cl = {st_node[L][NW-2:0], 1'b0};
                cr = {st_node[L][NW-2:0], 1'b1};
            end
            mhq_sift_unit #(.PW(PW), .SW(SW), .NW(NW)) u_sift (
                .node       (st_node[L]),
                .carry_prio (st_prio[L]),
                .carry_ptr  (st_ptr[L]),
                .left_prio  (hp_prio[cl]),
                .left_ptr   (hp_ptr[cl]),
                .right_prio (hp_prio[cr]),
                .right_ptr  (hp_ptr[cr]),
                .go_down    (st_go[L]),
                .next_node  (st_next[L]),
                .wr_prio    (st_wprio[L]),
                .wr_ptr     (st_wptr[L])
            );
        end else begin : g_leaf
            // Leaf level: the carried entry settles here.
            always_comb begin
                st_go[L]    = 1'b0;
                st_next[L]  = st_node[L];
                st_wprio[L] = st_prio[L];
                st_wptr[L]  = st_ptr[L];
            end
        end
    end

    // Stage registers: a root request enters stage 0, and a moving entry advances one level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int L = 0; L < D; L++) begin
                st_vld[L]  <= 1'b0;
                st_node[L] <= NW'(1);
                st_prio[L] <= '0;
                st_ptr[L]  <= '0;
            end
        end else begin
            st_vld[0]  <= acc_sink;
            st_node[0] <= NW'(1);
            st_prio[0] <= req_prio;
            st_ptr[0]  <= req_ptr;
            for (int L = 1; L < D; L++) begin
                st_vld[L]  <= st_vld[L-1] && st_go[L-1];
                st_node[L] <= st_next[L-1];
                st_prio[L] <= st_prio[L-1];
                st_ptr[L]  <= st_ptr[L-1];
            end
        end
    end

    // Heap storage and slot map: stage write-backs, or a one-cycle path lift for removal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 1; n <= K; n++) begin
                hp_prio[n] <= '0;
                hp_ptr[n]  <= SW'(n - 1);
            end
            for (int p = 0; p < K; p++) begin
                loc[p] <= NW'(p + 1);
            end
        end else if (acc_rise) begin
            for (int n = 2; n <= K; n++) begin
                if (up_mask[n]) begin
                    hp_prio[n]          <= hp_prio[n/2];
                    hp_ptr[n]           <= hp_ptr[n/2];
                    loc[hp_ptr[n/2]]    <= NW'(n);
                end
            end
            hp_prio[1]   <= '0;
            hp_ptr[1]    <= req_ptr;
            loc[req_ptr] <= NW'(1);
        end else begin
            for (int L = 0; L < D; L++) begin
                if (st_vld[L]) begin
                    hp_prio[st_node[L]] <= st_wprio[L];
                    hp_ptr[st_node[L]]  <= st_wptr[L];
                    loc[st_wptr[L]]     <= st_node[L];
                end
            end
        end
    end
endmodule

// File: rtl/mhq_heap_chk.sv
// Checker for mhq_heap, bound to every instance. It watches only ports.
module mhq_heap_chk #(
    parameter int K  = 15,
    parameter int PW = 8,
    parameter int NW = 4,
    parameter int SW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic [NW-1:0] req_node,
    input logic [PW-1:0] req_prio,
    input logic [SW-1:0] req_ptr,
    input logic [PW-1:0] min_prio,
    input logic [SW-1:0] min_ptr,
    input logic [SW-1:0] map_ptr,
    input logic [NW-1:0] map_node
);
    logic acc_root;
    logic acc_other;

    // Classify accepted requests.
    always_comb begin
        acc_root  = req_valid && req_ready && (req_node == NW'(1));
        acc_other = req_valid && req_ready && (req_node != NW'(1));
    end

    p_root_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_root |=> !req_ready);

    p_rise_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_other |=> (min_prio == '0) && (min_ptr == $past(req_ptr)));

    p_root_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_root |-> ##2 (min_prio <= $past(req_prio, 2)));

    p_map_root_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (map_ptr == min_ptr) |-> (map_node == NW'(1)));
endmodule

bind mhq_heap mhq_heap_chk #(.K(K), .PW(PW), .NW(NW), .SW(SW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_node  (req_node),
    .req_prio  (req_prio),
    .req_ptr   (req_ptr),
    .min_prio  (min_prio),
    .min_ptr   (min_ptr),
    .map_ptr   (map_ptr),
    .map_node  (map_node)
);

// File: tb/mhq_heap_tb.sv
// Bench for mhq_heap with K = 15: sweeps of computed priorities against a per-slot model.
module mhq_heap_tb;
    localparam int CLK_PER = 10;
    localparam int K  = 15;
    localparam int PW = 8;
    localparam int NW = 4;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [NW-1:0] req_node = 4'd1;
    logic [PW-1:0] req_prio = '0;
    logic [SW-1:0] req_ptr = '0;
    logic [PW-1:0] min_prio;
    logic [SW-1:0] min_ptr;
    logic [PW-1:0] cmp_freq = '0;
    logic          cmp_ge;
    logic [SW-1:0] map_ptr = '0;
    logic [NW-1:0] map_node;

    int total = 0;
    int bad = 0;
    int mprio [K];

    always #(CLK_PER/2) clk = ~clk;

    mhq_heap #(.K(K), .PW(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_prio(req_prio), .req_ptr(req_ptr),
        .min_prio(min_prio), .min_ptr(min_ptr), .cmp_freq(cmp_freq), .cmp_ge(cmp_ge),
        .map_ptr(map_ptr), .map_node(map_node)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Minimum, root slot and comparator against the model.
    task automatic check_state(input string tag);
        int mn;
        mn = 1 << PW;
        for (int p = 0; p < K; p++) if (mprio[p] < mn) mn = mprio[p];
        chk(int'(min_prio) == mn, {tag, " R2 min_prio"}, min_prio, mn);
        chk(mprio[min_ptr] == int'(min_prio), {tag, " R2 min_ptr prio"}, mprio[min_ptr], min_prio);
        cmp_freq = PW'(mn); #1;
        chk(cmp_ge == 1'b1, "R3 equal", cmp_ge, 1);
        if (mn > 0) begin
            cmp_freq = PW'(mn - 1); #1;
            chk(cmp_ge == 1'b0, "R3 below", cmp_ge, 0);
        end
        if (mn < 255) begin
            cmp_freq = PW'(mn + 1); #1;
            chk(cmp_ge == 1'b1, "R3 above", cmp_ge, 1);
        end
    endtask

    // Root replace reusing the root slot, as the victim storage would.
    task automatic ins(input int pr);
        @(negedge clk);
        req_node = 4'd1; req_prio = PW'(pr); req_valid = 1'b1; #1;
        while (!req_ready) begin @(negedge clk); #1; end
        req_ptr = min_ptr;
        mprio[min_ptr] = pr;
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b0, "R6 gap after root accept", req_ready, 0);
        @(negedge clk);
        chk(req_ready == 1'b1, "R6 ready returns", req_ready, 1);
        check_state("R4 R8");
    endtask

    // Removal of slot p, located through the map.
    task automatic del(input int p);
        logic [NW-1:0] nd;
        repeat (6) @(negedge clk);
        map_ptr = SW'(p); #1;
        nd = map_node;
        chk(nd >= 1 && nd <= K, "R7 map range", nd, 1);
        req_node = nd; req_ptr = SW'(p); req_prio = 8'hAB; req_valid = 1'b1; #1;
        chk(req_ready == 1'b1, "R6 removal when idle", req_ready, 1);
        @(posedge clk); #1 req_valid = 1'b0;
        mprio[p] = 0;
        chk(min_prio == '0, "R5 zero at root", min_prio, 0);
        chk(int'(min_ptr) == p, "R5 slot at root", min_ptr, p);
    endtask

    // Map is a permutation of 1..K with the root slot at node 1.
    task automatic map_check();
        logic [K:1] seen;
        seen = '0;
        repeat (6) @(negedge clk);
        for (int p = 0; p < K; p++) begin
            map_ptr = SW'(p); #1;
            chk(map_node >= 1 && map_node <= K && !seen[map_node], "R7 permutation", map_node, p);
            if (map_node >= 1 && map_node <= K) seen[map_node] = 1'b1;
        end
        map_ptr = min_ptr; #1;
        chk(map_node == 4'd1, "R7 root slot", map_node, 1);
    endtask

    initial begin
        #(CLK_PER * 150000);
        total++; bad++;
        $display("FAIL R6 watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int p = 0; p < K; p++) mprio[p] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(min_prio == '0, "R1 min_prio", min_prio, 0);
        chk(min_ptr == '0, "R1 min_ptr", min_ptr, 0);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        for (int p = 0; p < K; p++) begin
            map_ptr = SW'(p); #1;
            chk(int'(map_node) == p + 1, "R1 map", map_node, p + 1);
        end

        // R9 path lift: removal at node 5 (slot 4)
        del(4);
        @(negedge clk);
        map_ptr = 4'd0; #1; chk(map_node == 4'd2, "R9 slot0 to node2", map_node, 2);
        map_ptr = 4'd1; #1; chk(map_node == 4'd5, "R9 slot1 to node5", map_node, 5);
        map_ptr = 4'd4; #1; chk(map_node == 4'd1, "R9 slot4 to root", map_node, 1);

        // R6 removal blocked while a sink is in flight, root accepted
        @(negedge clk);
        req_node = 4'd1; req_prio = 8'd50; req_ptr = min_ptr; req_valid = 1'b1; #1;
        mprio[min_ptr] = 50;
        @(posedge clk); #1 req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        req_node = 4'd3; #1;
        chk(req_ready == 1'b0, "R6 removal held while sinking", req_ready, 0);
        req_node = 4'd1; #1;
        chk(req_ready == 1'b1, "R6 root open while sinking", req_ready, 1);
        check_state("R4");
        map_check();

        // R8 bursts of overlapping root replaces
        for (int i = 0; i < 60; i++) ins(((i * 53 + 17) % 200) + 1);
        map_check();

        // R5 removal of every slot, interleaved with inserts
        for (int p = 0; p < K; p++) begin
            del(p);
            ins(((p * 29 + 3) % 90) + 5);
            map_check();
        end

        // Ties
        for (int i = 0; i < 40; i++) ins((i % 3) + 5);
        map_check();

        // R3 exhaustive comparator sweep at current root
        for (int f = 0; f < 256; f++) begin
            cmp_freq = PW'(f); #1;
            chk(cmp_ge == (f >= int'(min_prio)), "R3 sweep", cmp_ge, f >= int'(min_prio));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule